// File: doc/BRIEF.md
# Tile Power Budget Distributor

This block hands out a chip-wide power budget to the tiles of a many-core die at the start of every fine-grain control interval (nominally 1 ms). On an interval pulse it captures the budget, the retired-instruction count each tile reported for the interval just finished, and each tile's preferred voltage/frequency level. It then works through the tiles one at a time. A sequential fixed-point divider computes each tile's share of the budget, in proportion to that tile's fraction of chip-wide throughput. The tile keeps the frequency level its most frequency-sensitive thread asks for, and its core size is stepped down until the tile's estimated power fits the share.

The per-tile power estimate for every (frequency level, core size) pair arrives as a table on an input port. It must be held stable from the interval pulse until the done pulse. When the levels of a tile change, the block holds that tile stalled for the reconfiguration time. A single done pulse marks the point where every tile has settled for the interval.

Top module: `tile_budget_distributor`

## Requirements
- R1: After reset every tile reports frequency level 2 and core level 3, every tile budget is 0, and `tile_stall` and `interval_done` are low.
- R2: A one-cycle `interval_start` while idle captures `total_budget`, `tile_insts` and `tile_vf_pref`, and starts a new interval. `interval_done` is high for exactly one cycle, in the cycle when the results of the last tile first appear.
- R3: In the first interval after reset no cap is applied. Every tile gets frequency level 2 (1.2 GHz, 0.8 V) and core level 3 (128-entry reorder buffer), and a budget of floor(total / NUM_TILES).
- R4: In later intervals the budget of tile t is floor(total × insts[t] / Σ insts), so the tile budgets never add up to more than the total.
- R5: If every tile reports zero instructions, each tile gets floor(total / NUM_TILES).
- R6: After the first interval the frequency level of a tile equals its captured preference. The levels are 0 = 0.8 GHz/0.7 V, 1 = 1.0 GHz/0.75 V and 2 = 1.2 GHz/0.8 V, and a preference of 3 is treated as 2.
- R7: After the first interval the core level is the largest c in 3, 2, 1, 0 (reorder buffer of 16 × 2^c entries) whose power entry is at most the tile budget, or 0 if no level fits. The entry for tile t, frequency level v and core level c sits at bit offset ((t·3 + v)·4 + c)·PWR_W of `tile_power`.
- R8: When the levels of a tile change, its `tile_stall` bit rises in the same cycle the new levels appear and stays high for exactly STALL_CYC cycles (200, which is 2 µs at 100 MHz). A tile whose levels do not change is not stalled.
- R9: An `interval_start` pulse that arrives while an interval is still being computed is ignored. The results follow the values captured first, and only one done pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval_start | input | 1 | One-cycle pulse at each fine-grain interval |
| total_budget | input | BUD_W | Chip-wide power budget |
| tile_insts | input | NUM_TILES·CNT_W | Per-tile instruction counts from the previous interval |
| tile_vf_pref | input | NUM_TILES·2 | Per-tile preferred frequency level |
| tile_power | input | NUM_TILES·3·4·PWR_W | Per-tile power estimate for each frequency/core level pair |
| tile_budget | output | NUM_TILES·BUD_W | Per-tile budget |
| tile_vf | output | NUM_TILES·2 | Chosen frequency level per tile |
| tile_core | output | NUM_TILES·2 | Chosen core level per tile |
| tile_stall | output | NUM_TILES | Reconfiguration stall per tile |
| interval_done | output | 1 | Pulse when all tiles have settled |

## Verification
Each tile costs one load cycle, NUM_W divider cycles, one capture cycle, at most three core step-down cycles and one commit cycle. The done pulse therefore arrives between roughly 4·(NUM_W+3) and 4·(NUM_W+6) cycles after the interval pulse. The bench does not count those cycles itself: it waits for `interval_done` at falling edges and compares every tile output in that same sample, when all tiles have committed. The stall monitor samples at every falling edge. It checks that a level change coincides with a raised stall bit and that each stall run lasts exactly STALL_CYC samples. It tallies stall rises only after all stall bits have dropped again, so no count races the last tile's commit.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DIV,
    ST_FIT,
    ST_COMMIT
  } dist_state_e;

  // Flat slot number of a power-table entry: tile-major, then level, then core.
  function automatic int unsigned tbl_slot(input int unsigned tile,
                                           input int unsigned vf,
                                           input int unsigned core,
                                           input int unsigned n_vf,
                                           input int unsigned n_core);
    return (tile * n_vf + vf) * n_core + core;
  endfunction

endpackage

// File: rtl/tpb_divider.sv
module tpb_divider #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quot,
  output logic             valid
);
  localparam int CW = $clog2(NUM_W + 1);

  logic             busy_q, valid_q;
  logic [CW-1:0]    cnt_q;
  logic [NUM_W-1:0] q_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [DEN_W:0]   trial, trial_sub;
  logic             take;

  assign trial     = {rem_q, q_q[NUM_W-1]};
  assign take      = trial >= {1'b0, den_q};
  assign trial_sub = trial - {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      cnt_q   <= '0;
      q_q     <= '0;
      rem_q   <= '0;
      den_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(NUM_W);
        q_q    <= num;
        rem_q  <= '0;
        den_q  <= den;
      end else if (busy_q) begin
        rem_q <= take ? trial_sub[DEN_W-1:0] : trial[DEN_W-1:0];
        q_q   <= {q_q[NUM_W-2:0], take};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q  <= 1'b0;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign quot  = q_q;
  assign valid = valid_q;

  assert_no_zero_den_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (den != '0));
  assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < den_q));

endmodule

// File: rtl/tpb_stall_timer.sv
module tpb_stall_timer #(
  parameter int STALL_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic stall
);
  localparam int SW = $clog2(STALL_CYC + 1);

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= SW'(STALL_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - SW'(1);
  end

  assign stall = (cnt_q != '0);

  assert_stall_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> stall);
  assert_no_spurious_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !stall) |=> !stall);
  assert_stall_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == SW'(1)) |=> !stall);

endmodule

// File: rtl/tile_budget_distributor.sv
module tile_budget_distributor #(
  parameter int NUM_TILES = 4,
  parameter int CNT_W     = 16,
  parameter int BUD_W     = 16,
  parameter int PWR_W     = 12,
  parameter int NUM_VF    = 3,
  parameter int NUM_CORE  = 4,
  parameter int STALL_CYC = 200
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       interval_start,
  input  logic [BUD_W-1:0]                           total_budget,
  input  logic [NUM_TILES*CNT_W-1:0]                 tile_insts,
  input  logic [NUM_TILES*$clog2(NUM_VF)-1:0]        tile_vf_pref,
  input  logic [NUM_TILES*NUM_VF*NUM_CORE*PWR_W-1:0] tile_power,
  output logic [NUM_TILES*BUD_W-1:0]                 tile_budget,
  output logic [NUM_TILES*$clog2(NUM_VF)-1:0]        tile_vf,
  output logic [NUM_TILES*$clog2(NUM_CORE)-1:0]      tile_core,
  output logic [NUM_TILES-1:0]                       tile_stall,
  output logic                                       interval_done
);
  import tpb_pkg::*;

  localparam int VF_W   = $clog2(NUM_VF);
  localparam int CORE_W = $clog2(NUM_CORE);
  localparam int SUM_W  = CNT_W + $clog2(NUM_TILES);
  localparam int NUM_W  = BUD_W + CNT_W;
  localparam int IDX_W  = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1;
  localparam int CMP_W  = BUD_W + PWR_W;
  localparam logic [VF_W-1:0]   VF_MAX   = VF_W'(NUM_VF - 1);
  localparam logic [CORE_W-1:0] CORE_MAX = CORE_W'(NUM_CORE - 1);

  dist_state_e state_q;
  logic [IDX_W-1:0]           idx_q;
  logic                       first_q, done_q;
  logic [BUD_W-1:0]           cap_total;
  logic [NUM_TILES*CNT_W-1:0] cap_insts;
  logic [NUM_TILES*VF_W-1:0]  cap_pref;
  logic [BUD_W-1:0]           share_q;
  logic [VF_W-1:0]            fit_vf;
  logic [CORE_W-1:0]          fit_core;

  // Named internal events used by the assertions.
  logic             commit_evt, over_share, fit_step, busy, sum_zero;
  logic [SUM_W-1:0] ips_sum;
  logic [CNT_W-1:0] ips_cur;
  logic [VF_W-1:0]  pref_cur, vf_pick;
  logic [PWR_W-1:0] pwr_cur;
  logic [NUM_W-1:0] div_num, div_quot;
  logic [SUM_W-1:0] div_den;
  logic             div_start, div_valid;

  always_comb begin
    ips_sum = '0;
    for (int t = 0; t < NUM_TILES; t++)
      ips_sum = ips_sum + SUM_W'(cap_insts[t*CNT_W +: CNT_W]);
  end

  assign sum_zero = (ips_sum == '0);
  assign ips_cur  = cap_insts[32'(idx_q)*CNT_W +: CNT_W];
  assign pref_cur = cap_pref[32'(idx_q)*VF_W +: VF_W];
  assign vf_pick  = (pref_cur > VF_MAX) ? VF_MAX : pref_cur;

  always_comb begin
    if (first_q || sum_zero) begin
      div_num = NUM_W'(cap_total);
      div_den = SUM_W'(NUM_TILES);
    end else begin
      div_num = NUM_W'(cap_total) * NUM_W'(ips_cur);
      div_den = ips_sum;
    end
  end

  assign pwr_cur = tile_power[tbl_slot(32'(idx_q), 32'(fit_vf), 32'(fit_core),
                                       NUM_VF, NUM_CORE)*PWR_W +: PWR_W];
  assign over_share = CMP_W'(pwr_cur) > CMP_W'(share_q);
  assign busy       = (state_q != ST_IDLE);
  assign commit_evt = (state_q == ST_COMMIT);
  assign fit_step   = (state_q == ST_FIT) && over_share && (fit_core != '0);
  assign div_start  = (state_q == ST_LOAD);

  tpb_divider #(.NUM_W(NUM_W), .DEN_W(SUM_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (div_num),
    .den   (div_den),
    .quot  (div_quot),
    .valid (div_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      first_q   <= 1'b1;
      done_q    <= 1'b0;
      cap_total <= '0;
      cap_insts <= '0;
      cap_pref  <= '0;
      share_q   <= '0;
      fit_vf    <= VF_MAX;
      fit_core  <= CORE_MAX;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (interval_start) begin
          cap_total <= total_budget;
          cap_insts <= tile_insts;
          cap_pref  <= tile_vf_pref;
          idx_q     <= '0;
          state_q   <= ST_LOAD;
        end
        ST_LOAD: state_q <= ST_DIV;
        ST_DIV: if (div_valid) begin
          share_q  <= div_quot[BUD_W-1:0];
          fit_core <= CORE_MAX;
          fit_vf   <= first_q ? VF_MAX : vf_pick;
          state_q  <= first_q ? ST_COMMIT : ST_FIT;
        end
        ST_FIT: begin
          if (fit_step) fit_core <= fit_core - CORE_W'(1);
          else          state_q  <= ST_COMMIT;
        end
        ST_COMMIT: begin
          if (idx_q == IDX_W'(NUM_TILES - 1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            first_q <= 1'b0;
          end else begin
            idx_q   <= idx_q + IDX_W'(1);
            state_q <= ST_LOAD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign interval_done = done_q;

  for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
    logic              mine, chg;
    logic [BUD_W-1:0]  bud_q;
    logic [VF_W-1:0]   vf_q;
    logic [CORE_W-1:0] core_q;

    assign mine = commit_evt && (idx_q == IDX_W'(t));
    assign chg  = mine && ((vf_q != fit_vf) || (core_q != fit_core));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bud_q  <= '0;
        vf_q   <= VF_MAX;
        core_q <= CORE_MAX;
      end else if (mine) begin
        bud_q  <= share_q;
        vf_q   <= fit_vf;
        core_q <= fit_core;
      end
    end

    assign tile_budget[t*BUD_W +: BUD_W]  = bud_q;
    assign tile_vf[t*VF_W +: VF_W]        = vf_q;
    assign tile_core[t*CORE_W +: CORE_W]  = core_q;

    tpb_stall_timer #(.STALL_CYC(STALL_CYC)) u_stall (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (chg),
      .stall (tile_stall[t])
    );
  end

  assert_share_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> (share_q <= cap_total));
  assert_core_fits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_evt && !first_q) |-> (!over_share || fit_core == '0));
  assert_first_uncapped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_evt && first_q) |-> (fit_vf == VF_MAX && fit_core == CORE_MAX));
  assert_vf_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> (fit_vf <= VF_MAX));
  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && interval_start) |=> $stable(cap_total));
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    interval_done |=> !interval_done);

endmodule

// File: tb/tile_budget_distributor_bench.sv
module tile_budget_distributor_bench;
  localparam int NT = 4, CW = 16, BW = 16, PW = 12, NV = 3, NC = 4, SC = 200;

  logic clk = 1'b0, rst_n = 1'b0, istart = 1'b0;
  logic [BW-1:0] total_budget = '0;
  logic [NT*CW-1:0] tile_insts = '0;
  logic [NT*2-1:0] tile_vf_pref = '0;
  logic [NT*NV*NC*PW-1:0] tile_power = '0;
  logic [NT*BW-1:0] tile_budget;
  logic [NT*2-1:0] tile_vf, tile_core;
  logic [NT-1:0] tile_stall;
  logic interval_done;

  always #5 clk = ~clk;

  tile_budget_distributor #(.NUM_TILES(NT), .CNT_W(CW), .BUD_W(BW), .PWR_W(PW),
    .NUM_VF(NV), .NUM_CORE(NC), .STALL_CYC(SC)) u_tile_budget_distributor (
    .clk(clk), .rst_n(rst_n), .interval_start(istart), .total_budget(total_budget),
    .tile_insts(tile_insts), .tile_vf_pref(tile_vf_pref), .tile_power(tile_power),
    .tile_budget(tile_budget), .tile_vf(tile_vf), .tile_core(tile_core),
    .tile_stall(tile_stall), .interval_done(interval_done));

  int n_checks = 0, n_fail = 0, stall_rises = 0, done_cnt = 0;
  bit finished = 0;
  int unsigned ips [NT];
  int unsigned pref [NT];
  int unsigned pwr [NT][NV][NC];
  int unsigned total;
  bit first_iv = 1;
  int unsigned prev_vf [NT], prev_core [NT];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Bench-side model of the share, level and core choice.
  function automatic int unsigned exp_share(input int t);
    longint unsigned s = 0;
    for (int i = 0; i < NT; i++) s += ips[i];
    if (first_iv || s == 0) return total / NT;
    return int'((longint'(total) * ips[t]) / s);
  endfunction
  function automatic int unsigned exp_vf(input int t);
    if (first_iv) return NV - 1;
    return (pref[t] > NV - 1) ? NV - 1 : pref[t];
  endfunction
  function automatic int unsigned exp_core(input int t);
    int c = NC - 1;
    if (first_iv) return NC - 1;
    while (c > 0 && pwr[t][exp_vf(t)][c] > exp_share(t)) c--;
    return c;
  endfunction

  task automatic drive_inputs();
    total_budget = BW'(total);
    for (int t = 0; t < NT; t++) begin
      tile_insts[t*CW +: CW] = CW'(ips[t]);
      tile_vf_pref[t*2 +: 2] = 2'(pref[t]);
      for (int v = 0; v < NV; v++)
        for (int c = 0; c < NC; c++)
          tile_power[((t*NV + v)*NC + c)*PW +: PW] = PW'(pwr[t][v][c]);
    end
  endtask

  task automatic randomize_inputs(input int unsigned ips_max);
    total = $urandom_range(0, 3000);
    for (int t = 0; t < NT; t++) begin
      ips[t] = $urandom_range(0, ips_max);
      pref[t] = $urandom_range(0, 3);
      for (int v = 0; v < NV; v++)
        for (int c = 0; c < NC; c++)
          pwr[t][v][c] = $urandom_range(0, 1500);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (interval_done) begin ok = 1; break; end
    end
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (tile_stall == '0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // One interval: pulse, wait for done, compare every tile, then count stalls.
  task automatic run_interval(input string tag, input bit late_pulse);
    bit ok;
    int exp_chg = 0;
    int unsigned e_s, e_v, e_c;
    int unsigned keep_total;
    int d0;
    stall_rises = 0;
    d0 = done_cnt;
    drive_inputs();
    @(negedge clk); istart = 1'b1;
    @(negedge clk); istart = 1'b0;
    if (late_pulse) begin
      // R9: a second pulse with different inputs while busy must be ignored.
      keep_total = total;
      repeat (10) @(negedge clk);
      total_budget = ~total_budget;
      tile_insts = ~tile_insts;
      tile_vf_pref = ~tile_vf_pref;
      istart = 1'b1;
      @(negedge clk); istart = 1'b0;
      total = keep_total;
    end
    wait_done(ok);
    chk(ok, "R2", {tag, " done pulse seen"}, ok, 1);
    for (int t = 0; t < NT; t++) begin
      e_s = exp_share(t); e_v = exp_vf(t); e_c = exp_core(t);
      chk(tile_budget[t*BW +: BW] == BW'(e_s), first_iv ? "R3" : "R4",
          {tag, " budget"}, tile_budget[t*BW +: BW], e_s);
      chk(tile_vf[t*2 +: 2] == 2'(e_v), "R6", {tag, " vf level"}, tile_vf[t*2 +: 2], e_v);
      chk(tile_core[t*2 +: 2] == 2'(e_c), "R7", {tag, " core level"}, tile_core[t*2 +: 2], e_c);
      if (e_v != prev_vf[t] || e_c != prev_core[t]) exp_chg++;
      prev_vf[t] = e_v; prev_core[t] = e_c;
    end
    drive_inputs();
    wait_quiet();
    chk(stall_rises == exp_chg, "R8", {tag, " stalled tiles"}, stall_rises, exp_chg);
    chk(done_cnt - d0 == 1, late_pulse ? "R9" : "R2", {tag, " done count"}, done_cnt - d0, 1);
    first_iv = 0;
  endtask

  // Stall monitor: a level change must come with a stall, and each run lasts SC samples.
  int run_len [NT];
  logic [NT*2-1:0] mon_vf, mon_core;
  logic [NT-1:0] mon_stall;
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) run_len[t] = 0;
      mon_vf = tile_vf; mon_core = tile_core; mon_stall = tile_stall;
    end else begin
      if (interval_done) done_cnt++;
      for (int t = 0; t < NT; t++) begin
        if (tile_stall[t] && !mon_stall[t]) stall_rises++;
        if (tile_vf[t*2 +: 2] != mon_vf[t*2 +: 2] || tile_core[t*2 +: 2] != mon_core[t*2 +: 2])
          chk(tile_stall[t], "R8", "stall with level change", tile_stall[t], 1);
        if (tile_stall[t]) run_len[t]++;
        else if (mon_stall[t]) begin
          chk(run_len[t] == SC, "R8", "stall length", run_len[t], SC);
          run_len[t] = 0;
        end
      end
      mon_vf = tile_vf; mon_core = tile_core; mon_stall = tile_stall;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "R2", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int t = 0; t < NT; t++) begin prev_vf[t] = NV - 1; prev_core[t] = NC - 1; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state.
    for (int t = 0; t < NT; t++) begin
      chk(tile_vf[t*2 +: 2] == 2'd2, "R1", "reset vf", tile_vf[t*2 +: 2], 2);
      chk(tile_core[t*2 +: 2] == 2'd3, "R1", "reset core", tile_core[t*2 +: 2], 3);
      chk(tile_budget[t*BW +: BW] == '0, "R1", "reset budget", tile_budget[t*BW +: BW], 0);
    end
    chk(tile_stall == '0, "R1", "reset stall", tile_stall, 0);
    chk(!interval_done, "R1", "reset done", interval_done, 0);

    // R3: first interval is uncapped even with tiny power headroom.
    randomize_inputs(60000);
    total = 2999;
    run_interval("first", 0);

    // R5: all tiles idle -> equal split.
    randomize_inputs(0);
    total = 1003;
    run_interval("zero_sum", 0);

    // R4/R7: one tile owns all throughput, others get nothing and drop to core 0.
    randomize_inputs(0);
    total = 2500;
    ips[2] = 40000;
    for (int t = 0; t < NT; t++) pref[t] = 1;
    run_interval("one_hot", 0);

    // R6: preference 3 clamps to level 2; max counts exercise the widest product.
    randomize_inputs(65535);
    total = 65535;
    for (int t = 0; t < NT; t++) begin pref[t] = 3; ips[t] = 65535 - t; end
    run_interval("clamp_wide", 0);

    // R8: same inputs again -> no level change, no stall.
    run_interval("repeat", 0);

    for (int k = 0; k < 8; k++) begin
      randomize_inputs(65535);
      run_interval("random", 0);
    end

    // R9: pulse while busy is ignored.
    randomize_inputs(30000);
    run_interval("busy_pulse", 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule